// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the control side of operand forwarding and interlocking for an in-order integer pipeline with five stages: fetch, decode/register read, execute (ALU), data memory and register write. Each cycle the decoder presents the instruction now in decode/register read: its class, two source register IDs, a destination ID and a writes-register flag. The controller keeps its own copy of the destination information of the instructions in the ALU and data-memory stages. From these it decides whether the decode instruction must wait. It also chooses, one cycle ahead, which pipeline latch feeds each execute operand. Finally it decides when fetch must give up the single shared memory port to a load or store.

The operand selects are worked out while the consumer sits in decode and are held in registers for the execute cycle that follows. A store whose data comes from the load just ahead of it is not stalled. Instead it gets a late select that takes the loaded value straight into the memory write. Clearing the bypass-enable input turns forwarding off entirely, so every dependent instruction waits until its producer reaches register write. The register file writes early in the cycle and reads late, so no wait is needed once the producer is there.

Top module: `hazard_ctrl`

## Requirements
- R1: An active-high synchronous reset empties the tracked ALU and DM stages. On the first cycle after reset, `sel_a`, `sel_b` and `sel_st` are 00 and `fetch_hold` is 0.
- R2: Operand select codes are 00 for the register file, 01 for the ALU/DM latch and 10 for the DM/RW latch. With bypass on, a source that matches the destination of an ALU-class instruction one ahead gives select 01 in the consumer's execute cycle, with no stall.
- R3: With bypass on, a source that matches the destination of an ALU or load instruction two ahead gives select 10 in the consumer's execute cycle.
- R4: When the instruction one ahead and the instruction two ahead both write a source register, the nearer one wins (select 01).
- R5: Register 0 never matches. An instruction with its writes-register flag clear never matches. Class store (10) and class branch (11) never count as producers. A load (class 01) uses only its first source, so its second source field is ignored.
- R6: Class encoding is 00 ALU, 01 load, 10 store, 11 branch. The first source is the ALU operand or address base, and the second source is the ALU operand, compare operand or store data. With bypass on, a first-source use (any class) or a second-source use by an ALU or branch instruction of a load one ahead asserts `stall` for exactly one cycle. An empty slot then enters the ALU stage, so both operand selects read 00 in the next cycle. After the wait the consumer gets select 10.
- R7: With bypass on, a store whose second source (data) matches a load one ahead is not stalled. Its `sel_b` is 00, and one cycle later (its DM cycle) `sel_st` is 10. Otherwise `sel_st` is 00.
- R8: With bypass off, all operand selects are 00, and a consumer stalls while its producer is in the ALU or DM stage. A dependent instruction right behind its producer therefore stalls two cycles, and one with a single instruction between stalls one cycle.
- R9: While a load or store is in the DM stage, `fetch_hold` is 1. `dr_bubble` is 1 when `fetch_hold` is 1 and `stall` is 0, meaning no new instruction enters decode next cycle. During a stall, fetch and decode are frozen together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | 1 = forward results, 0 = wait for register write |
| dr_valid | input | 1 | Decode stage holds an instruction |
| dr_class | input | 2 | Decode instruction class (00 ALU, 01 load, 10 store, 11 branch) |
| dr_rs1 | input | 5 | First source: ALU operand or address base |
| dr_rs2 | input | 5 | Second source: ALU/compare operand or store data |
| dr_rd | input | 5 | Destination register |
| dr_wr | input | 1 | Decode instruction writes its destination |
| sel_a | output | 2 | Registered select for execute operand A |
| sel_b | output | 2 | Registered select for execute operand B |
| sel_st | output | 2 | Registered store-data select for the DM stage |
| stall | output | 1 | Freeze fetch and decode, send an empty slot to ALU |
| fetch_hold | output | 1 | Memory port given to the DM stage this cycle |
| dr_bubble | output | 1 | Decode receives no new instruction next cycle |

## Verification
The hardest case to reach is the load-to-store data forward. It only appears when a load and a store that writes the loaded register enter decode on consecutive cycles. The port conflict of any earlier load or store breaks that adjacency with an empty decode slot. Directed sequences first drain the pipeline and then issue the pair back to back, so the late select is seen in the store's memory cycle. The random phase draws all registers from a pool of four and mixes in bypass toggling, so this pairing, stalls that coincide with port conflicts, and double matches all recur many times.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    localparam int REG_AW  = 5;
    localparam int NUM_SRC = 2;
    localparam int SEL_W   = 2;

    typedef logic [REG_AW-1:0] reg_id_t;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'b00,
        CLS_LOAD   = 2'b01,
        CLS_STORE  = 2'b10,
        CLS_BRANCH = 2'b11
    } iclass_e;

    typedef enum logic [SEL_W-1:0] {
        BYP_RF = 2'b00,
        BYP_XM = 2'b01,
        BYP_MW = 2'b10
    } byp_sel_e;

    typedef struct packed {
        logic    vld;
        iclass_e cls;
        logic    wr;
        reg_id_t rd;
    } stage_t;

    // A stage produces register r only if it really writes a nonzero destination
    function automatic logic is_producer_of(stage_t s, reg_id_t r);
        return s.vld && s.wr && (s.rd != '0) &&
               (s.cls == CLS_ALU || s.cls == CLS_LOAD) && (s.rd == r);
    endfunction

    // Loads read only their address base
    function automatic logic src_used(iclass_e c, int unsigned idx);
        return (idx == 0) || (c != CLS_LOAD);
    endfunction

endpackage

// File: rtl/hzc_stage_track.sv
module hzc_stage_track
    import hzc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stall,
    input  stage_t dr_in,
    output stage_t ex_q,
    output stage_t mem_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q  <= '0;
            mem_q <= '0;
        end else begin
            ex_q  <= stall ? stage_t'('0) : dr_in;
            mem_q <= ex_q;
        end
    end

endmodule

// File: rtl/hzc_src_unit.sv
module hzc_src_unit
    import hzc_pkg::*;
#(
    parameter int unsigned IDX = 0
) (
    input  logic     bypass_en,
    input  logic     dr_vld,
    input  iclass_e  dr_cls,
    input  reg_id_t  src,
    input  stage_t   ex_s,
    input  stage_t   mem_s,
    output byp_sel_e sel,
    output logic     hold,
    output logic     late
);

    logic used, hit_x, hit_m, store_data;

    always_comb begin
        used       = dr_vld && src_used(dr_cls, IDX);
        hit_x      = used && is_producer_of(ex_s, src);
        hit_m      = used && is_producer_of(mem_s, src);
        store_data = (IDX == 1) && (dr_cls == CLS_STORE);
        sel  = BYP_RF;
        hold = 1'b0;
        late = 1'b0;
        if (!bypass_en) begin
            hold = hit_x || hit_m;
        end else if (hit_x) begin
            if (ex_s.cls == CLS_LOAD) begin
                if (store_data) late = 1'b1;
                else            hold = 1'b1;
            end else begin
                sel = BYP_XM;
            end
        end else if (hit_m) begin
            sel = BYP_MW;
        end
    end

endmodule

// File: rtl/hzc_port_arb.sv
module hzc_port_arb
    import hzc_pkg::*;
(
    input  logic    dm_vld,
    input  iclass_e dm_cls,
    input  logic    stall,
    output logic    fetch_hold,
    output logic    dr_bubble
);

    always_comb begin
        fetch_hold = dm_vld && (dm_cls == CLS_LOAD || dm_cls == CLS_STORE);
        dr_bubble  = fetch_hold && !stall;
    end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hzc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bypass_en,
    input  logic             dr_valid,
    input  logic [1:0]       dr_class,
    input  logic [REG_AW-1:0] dr_rs1,
    input  logic [REG_AW-1:0] dr_rs2,
    input  logic [REG_AW-1:0] dr_rd,
    input  logic             dr_wr,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b,
    output logic [SEL_W-1:0] sel_st,
    output logic             stall,
    output logic             fetch_hold,
    output logic             dr_bubble
);

    stage_t   dr_s, ex_q, mem_q;
    reg_id_t  src_id [NUM_SRC];
    byp_sel_e sel_c  [NUM_SRC];
    byp_sel_e sel_q  [NUM_SRC];
    logic [NUM_SRC-1:0] hold_c, late_c;
    logic     st_pend_q;
    byp_sel_e st_sel_q;

    always_comb begin
        dr_s.vld  = dr_valid;
        dr_s.cls  = iclass_e'(dr_class);
        dr_s.wr   = dr_wr;
        dr_s.rd   = dr_rd;
        src_id[0] = dr_rs1;
        src_id[1] = dr_rs2;
    end

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        hzc_src_unit #(.IDX(gi)) u_src (
            .bypass_en (bypass_en),
            .dr_vld    (dr_valid),
            .dr_cls    (dr_s.cls),
            .src       (src_id[gi]),
            .ex_s      (ex_q),
            .mem_s     (mem_q),
            .sel       (sel_c[gi]),
            .hold      (hold_c[gi]),
            .late      (late_c[gi])
        );
    end

    assign stall = dr_valid && (|hold_c);

    hzc_stage_track u_track (
        .clk   (clk),
        .rst   (rst),
        .stall (stall),
        .dr_in (dr_s),
        .ex_q  (ex_q),
        .mem_q (mem_q)
    );

    hzc_port_arb u_arb (
        .dm_vld     (mem_q.vld),
        .dm_cls     (mem_q.cls),
        .stall      (stall),
        .fetch_hold (fetch_hold),
        .dr_bubble  (dr_bubble)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) sel_q[i] <= BYP_RF;
            st_pend_q <= 1'b0;
            st_sel_q  <= BYP_RF;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) sel_q[i] <= stall ? BYP_RF : sel_c[i];
            st_pend_q <= !stall && (|late_c);
            st_sel_q  <= st_pend_q ? BYP_MW : BYP_RF;
        end
    end

    assign sel_a  = sel_q[0];
    assign sel_b  = sel_q[1];
    assign sel_st = st_sel_q;

    // R1: tracked stages and selects come out of reset empty
    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_a == 2'b00 && sel_b == 2'b00 && sel_st == 2'b00 && !fetch_hold));

    // R6: with forwarding, only a load one ahead can hold decode
    a_r6_stall_needs_load: assert property (@(posedge clk) disable iff (rst)
        (stall && bypass_en) |-> (ex_q.vld && ex_q.cls == CLS_LOAD));

    // R6: the slot sent into ALU during a stall reads nothing forwarded
    a_r6_bubble_selects: assert property (@(posedge clk) disable iff (rst)
        stall |=> (sel_a == 2'b00 && sel_b == 2'b00));

    // R7: the late store-data select only accompanies a store in DM
    a_r7_late_store: assert property (@(posedge clk) disable iff (rst)
        (sel_st == 2'b10) |-> (mem_q.vld && mem_q.cls == CLS_STORE));

    // R8: no forwarding select follows a cycle with bypass off
    a_r8_no_fwd_when_off: assert property (@(posedge clk) disable iff (rst)
        $past(!bypass_en) |-> (sel_a == 2'b00 && sel_b == 2'b00));

    // R9: a memory op that moved into DM takes the port from fetch
    a_r9_port_to_data: assert property (@(posedge clk) disable iff (rst)
        $past(ex_q.vld && (ex_q.cls == CLS_LOAD || ex_q.cls == CLS_STORE)) |-> fetch_hold);

endmodule

// File: tb/hazard_ctrl_test.sv
`timescale 1ns/100ps
module hazard_ctrl_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bypass_en = 1'b1;
    logic dr_valid = 1'b0;
    logic [1:0] dr_class = 2'b00;
    logic [4:0] dr_rs1 = '0, dr_rs2 = '0, dr_rd = '0;
    logic dr_wr = 1'b0;
    logic [1:0] sel_a, sel_b, sel_st;
    logic stall, fetch_hold, dr_bubble;

    always #2.5 clk = ~clk;

    hazard_ctrl uut (
        .clk(clk), .rst(rst), .bypass_en(bypass_en),
        .dr_valid(dr_valid), .dr_class(dr_class),
        .dr_rs1(dr_rs1), .dr_rs2(dr_rs2), .dr_rd(dr_rd), .dr_wr(dr_wr),
        .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st),
        .stall(stall), .fetch_hold(fetch_hold), .dr_bubble(dr_bubble)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model of ALU and DM stage contents and registered selects
    logic       xv = 0, mv = 0, xw = 0, mw = 0;
    logic [1:0] xc = 0, mc = 0;
    logic [4:0] xd = 0, md = 0;
    logic [1:0] e_sa = 0, e_sb = 0, e_ss = 0;
    logic       e_pd = 0;
    logic       stall_last = 0, bub_pend = 0;
    logic       s_fh = 0, s_bub = 0;

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic hitp(logic v, logic [1:0] c, logic w, logic [4:0] d, logic [4:0] s);
        return v && w && d != 0 && (c == 2'd0 || c == 2'd1) && d == s;
    endfunction

    function automatic void src_model(input int idx, input logic v, input logic [1:0] c,
                                      input logic [4:0] s, output logic [1:0] sel,
                                      output logic hold, output logic late);
        logic used, hx, hm;
        used = v && (idx == 0 || c != 2'd1);
        hx = used && hitp(xv, xc, xw, xd, s);
        hm = used && hitp(mv, mc, mw, md, s);
        sel = 2'b00; hold = 0; late = 0;
        if (!bypass_en) hold = hx || hm;
        else if (hx) begin
            if (xc == 2'd1) begin
                if (idx == 1 && c == 2'd2) late = 1; else hold = 1;
            end else sel = 2'b01;
        end else if (hm) sel = 2'b10;
    endfunction

    task automatic cycle(input logic v, input logic [1:0] c, input logic [4:0] a,
                         input logic [4:0] b, input logic [4:0] d, input logic w);
        logic [1:0] s0, s1;
        logic h0, h1, l0, l1, es, efh;
        @(negedge clk);
        dr_valid = v; dr_class = c; dr_rs1 = a; dr_rs2 = b; dr_rd = d; dr_wr = w;
        #1;
        src_model(0, v, c, a, s0, h0, l0);
        src_model(1, v, c, b, s1, h1, l1);
        es  = v && (h0 || h1);
        efh = mv && (mc == 2'd1 || mc == 2'd2);
        check(stall, es, "R6 stall");
        check(fetch_hold, efh, "R9 fetch_hold");
        check(dr_bubble, efh && !es, "R9 dr_bubble");
        check(sel_a, e_sa, "R2 sel_a");
        check(sel_b, e_sb, "R3 sel_b");
        check(sel_st, e_ss, "R7 sel_st");
        s_fh = fetch_hold; s_bub = dr_bubble;
        @(posedge clk);
        e_ss = e_pd ? 2'b10 : 2'b00;
        e_pd = !es && (l0 || l1);
        e_sa = es ? 2'b00 : s0;
        e_sb = es ? 2'b00 : s1;
        mv = xv; mc = xc; mw = xw; md = xd;
        xv = v && !es; xc = c; xw = w; xd = d;
        stall_last = es;
        bub_pend = efh && !es;
        #1;
    endtask

    task automatic issue(input logic [1:0] c, input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] d, input logic w, output int nst);
        nst = 0;
        while (bub_pend) cycle(0, 0, 0, 0, 0, 0);
        cycle(1, c, a, b, d, w);
        while (stall_last) begin
            nst++;
            cycle(1, c, a, b, d, w);
        end
    endtask

    task automatic flush();
        repeat (3) cycle(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        int ns;
        void'($urandom(32'h1bad5eed));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        @(posedge clk); #1;
        check(sel_a, 0, "R1 sel_a after reset");
        check(sel_b, 0, "R1 sel_b after reset");
        check(sel_st, 0, "R1 sel_st after reset");
        check(fetch_hold, 0, "R1 fetch_hold after reset");
        flush();

        // R2: adjacent ALU producer
        issue(0, 2, 3, 1, 1, ns);
        issue(0, 1, 5, 4, 1, ns);
        check(ns, 0, "R2 no stall");
        check(sel_a, 1, "R2 sel_a from ALU/DM latch");
        // R3: producer two ahead
        flush();
        issue(0, 2, 3, 1, 1, ns);
        issue(0, 2, 3, 6, 1, ns);
        issue(0, 2, 1, 7, 1, ns);
        check(sel_b, 2, "R3 sel_b from DM/RW latch");
        check(sel_a, 0, "R3 sel_a register file");
        // R4: both ahead write the source
        flush();
        issue(0, 2, 3, 1, 1, ns);
        issue(0, 2, 3, 1, 1, ns);
        issue(0, 1, 1, 8, 1, ns);
        check(sel_a, 1, "R4 nearer wins a");
        check(sel_b, 1, "R4 nearer wins b");
        // R5: non-producers
        flush();
        issue(0, 2, 3, 0, 1, ns);
        issue(0, 0, 0, 9, 1, ns);
        check(sel_a, 0, "R5 register 0");
        flush();
        issue(0, 2, 3, 2, 0, ns);
        issue(0, 2, 2, 9, 1, ns);
        check(sel_a, 0, "R5 write flag clear");
        flush();
        issue(2, 5, 6, 3, 1, ns);
        issue(0, 3, 3, 9, 1, ns);
        check(sel_b, 0, "R5 store not producer");
        flush();
        issue(1, 6, 0, 4, 1, ns);
        issue(1, 7, 4, 9, 1, ns);
        check(ns, 0, "R5 load second source ignored");
        // R6: load-use
        flush();
        issue(1, 2, 0, 1, 1, ns);
        issue(0, 1, 4, 3, 1, ns);
        check(ns, 1, "R6 load-use stall count");
        check(sel_a, 2, "R6 sel_a after wait");
        flush();
        issue(1, 2, 0, 1, 1, ns);
        issue(2, 1, 5, 0, 0, ns);
        check(ns, 1, "R6 load feeds address base");
        // R7: load then store of loaded data
        flush();
        issue(1, 2, 0, 1, 1, ns);
        issue(2, 4, 1, 0, 0, ns);
        check(ns, 0, "R7 no stall");
        check(sel_b, 0, "R7 sel_b register file");
        cycle(0, 0, 0, 0, 0, 0);
        check(sel_st, 2, "R7 late store data");
        // R8: no forwarding
        bypass_en = 0;
        flush();
        issue(0, 2, 3, 1, 1, ns);
        issue(0, 1, 3, 4, 1, ns);
        check(ns, 2, "R8 adjacent wait");
        check(sel_a, 0, "R8 select register file");
        flush();
        issue(0, 2, 3, 1, 1, ns);
        issue(0, 2, 3, 6, 1, ns);
        issue(0, 3, 1, 4, 1, ns);
        check(ns, 1, "R8 gap of one");
        bypass_en = 1;
        // R9: port conflict
        flush();
        issue(1, 2, 0, 1, 1, ns);
        issue(0, 2, 3, 5, 1, ns);
        cycle(0, 0, 0, 0, 0, 0);
        check(s_fh, 1, "R9 load in DM holds fetch");
        check(s_bub, 1, "R9 decode bubble");

        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] c;
            logic w;
            if ($urandom % 64 == 0) bypass_en = ~bypass_en;
            if (stall_last) cycle(1, dr_class, dr_rs1, dr_rs2, dr_rd, dr_wr);
            else if (bub_pend) cycle(0, 0, 0, 0, 0, 0);
            else begin
                c = 2'($urandom % 4);
                w = (c <= 2'd1);
                if ($urandom % 8 == 0) w = ~w;
                cycle(($urandom % 10) != 0, c, 5'($urandom % 4), 5'($urandom % 4),
                      5'($urandom % 4), w);
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule